// File: doc/BRIEF.md
# Nibble-Wide Counter Register Interface

This block connects a processor with a 4-bit data bus to a 10-bit counter. Software writes a 10-bit start value in three parts: bits [3:0], bits [7:4] and bits [9:8]. A control word sets the count direction and the count enable. It also carries a load command, which moves the start value into the counter and then clears itself.

The live count is read back in three nibble reads. The read of the low nibble also copies count bits [9:4] into a shadow register. The middle and high reads return that shadow copy. A reader that fetches the low nibble first therefore gets one coherent 10-bit value, even while the counter is running.

Read data is registered. A read strobe in one cycle presents its data after the next clock edge, and that data is held until the next read.

Top module: `ctr_nib_regif`

## Requirements
- R1: After a synchronous active-low reset, the start value, count, shadow, enable, direction and read data are all 0.
- R2: The start value is written in three parts: bits [3:0] at address 0, bits [7:4] at address 1, and bits [9:8] from wdata[1:0] at address 2. Reads of addresses 0 to 2 return those parts, with bits [3:2] of address 2 reading 0. Address 7 reads 0.
- R3: Writing address 3 with bit 0 set copies the start value into the count on the following clock edge. Bit 0 of address 3 always reads 0.
- R4: With enable set (address 3 bit 1) and direction clear (bit 2 = 0), the count rises by 1 per clock and wraps from 1023 to 0. With enable clear, the count holds.
- R5: With enable set and direction set (bit 2 = 1), the count falls by 1 per clock and wraps from 0 to 1023.
- R6: A read of address 4 returns the live count bits [3:0] and, on the same edge, captures count bits [9:4] into the shadow register.
- R7: A read of address 5 returns shadow bits [3:0] (count [7:4]). A read of address 6 returns shadow bits [5:4] (count [9:8]) in rdata[1:0], with rdata[3:2] = 0. The live count is not used for either.
- R8: The shadow register keeps its value until the next read of address 4, including across loads and counting.
- R9: When a load and an enabled count step fall on the same edge, the load wins and the count equals the start value.
- R10: rdata changes only on an edge where rd_en is high, and then shows the addressed data from the cycle of the strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| wdata | input | 4 | Write data |
| rdata | output | 4 | Registered read data |

## Verification
The assertions assume that rd_en and wr_en are synchronous to clk and that addr and wdata are stable around each edge. They also assume that coherence is judged only for a low read followed by the middle and high reads, with no other low read in between.

The bench drives all inputs half a cycle away from the sampling edge. It always reads the three count nibbles in the order low, middle, high. Loads, direction changes and enable changes are placed between or inside those read groups on purpose, including back-to-back writes that put a load and a step on the same edge.

// File: rtl/ctr_nib_pkg.sv
// Package: shared sizes, control bit positions and the direction type
// of the nibble-wide counter register interface.
package ctr_nib_pkg;
    localparam int CNT_W  = 10;   // counter width
    localparam int DATA_W = 4;    // processor data bus width
    localparam int ADDR_W = 3;    // register address width

    // Bit positions inside the control word
    localparam int CB_LOAD = 0;
    localparam int CB_EN   = 1;
    localparam int CB_DIR  = 2;

    typedef enum logic {
        CNT_UP   = 1'b0,
        CNT_DOWN = 1'b1
    } cnt_dir_e;
endpackage

// File: rtl/ctr_nib_cfg.sv
// Module: ctr_nib_cfg
// Holds the start value, written one bus-wide piece per address, and the
// control bits (enable, direction). It also raises a one-cycle load pulse
// when the control word is written with the load bit set.
// Assumes: start-value pieces sit at addresses 0..NPIECE-1 and the control
// word sits at address NPIECE.
module ctr_nib_cfg
    import ctr_nib_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [CW-1:0] init_q,
    output logic          en_q,
    output cnt_dir_e      dir_q,
    output logic          load_q
);
    localparam int NPIECE = (CW + DW - 1) / DW;
    localparam int A_CTRL = NPIECE;

    logic ctrl_wr;

    // Purpose: decode a write to the control word
    always_comb begin
        ctrl_wr = wr_en && (addr == AW'(A_CTRL));
    end

    // Purpose: store start-value pieces and control bits; load pulse self-clears
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            init_q <= '0;
            en_q   <= 1'b0;
            dir_q  <= CNT_UP;
            load_q <= 1'b0;
        end else begin
            load_q <= ctrl_wr && wdata[CB_LOAD];
            if (ctrl_wr) begin
                en_q  <= wdata[CB_EN];
                dir_q <= cnt_dir_e'(wdata[CB_DIR]);
            end
            for (int b = 0; b < CW; b++) begin
                if (wr_en && (addr == AW'(b / DW))) begin
                    init_q[b] <= wdata[b % DW];
                end
            end
        end
    end
endmodule

// File: rtl/ctr_nib_core.sv
// Module: ctr_nib_core
// The counter itself: it loads the start value, steps up or down, or holds.
// A load has priority over a step, and the count wraps modulo 2**CW.
// Assumes: load is a single-cycle pulse.
module ctr_nib_core
    import ctr_nib_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] init,
    input  logic          en,
    input  cnt_dir_e      dir,
    output logic [CW-1:0] count_q
);
    logic [CW-1:0] stepped;

    // Purpose: next value for one count step in the chosen direction
    always_comb begin
        if (dir == CNT_DOWN) begin
            stepped = count_q - 1'b1;
        end else begin
            stepped = count_q + 1'b1;
        end
    end

    // Purpose: update the count; load wins over an enabled step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load) begin
            count_q <= init;
        end else if (en) begin
            count_q <= stepped;
        end
    end
endmodule

// File: rtl/ctr_nib_rdport.sv
// Module: ctr_nib_rdport
// Read side. A read of count piece 0 returns the live low bits and captures
// the upper count bits into a shadow register. Reads of the higher count
// pieces return the shadow. Read data is registered and held between reads.
// Assumes: address map = start pieces, control word, then count pieces.
module ctr_nib_rdport
    import ctr_nib_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [AW-1:0]    addr,
    input  logic [CW-1:0]    count,
    input  logic [CW-1:0]    init,
    input  logic             en,
    input  cnt_dir_e         dir,
    output logic [CW-DW-1:0] shadow_q,
    output logic [DW-1:0]    rdata
);
    localparam int NPIECE = (CW + DW - 1) / DW;
    localparam int EXT_W  = NPIECE * DW;
    localparam int A_CTRL = NPIECE;
    localparam int A_CNT0 = NPIECE + 1;

    logic [EXT_W-1:0] ext_init;
    logic [EXT_W-1:0] ext_cnt;
    logic [DW-1:0]    rd_next;
    logic             low_rd;

    // Purpose: zero-extend the start value and the shadowed count view
    always_comb begin
        ext_init = EXT_W'(init);
        ext_cnt  = EXT_W'({shadow_q, count[DW-1:0]});
    end

    // Purpose: pick the addressed read value; unmapped addresses read 0
    always_comb begin
        rd_next = '0;
        for (int p = 0; p < NPIECE; p++) begin
            if (addr == AW'(p)) begin
                rd_next = ext_init[p*DW +: DW];
            end
            if (addr == AW'(A_CNT0 + p)) begin
                rd_next = ext_cnt[p*DW +: DW];
            end
        end
        if (addr == AW'(A_CTRL)) begin
            rd_next[CB_EN]  = en;
            rd_next[CB_DIR] = dir;
        end
    end

    // Purpose: flag a read of the low count piece
    always_comb begin
        low_rd = rd_en && (addr == AW'(A_CNT0));
    end

    // Purpose: register read data and snapshot the upper count bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata    <= '0;
            shadow_q <= '0;
        end else begin
            if (rd_en) begin
                rdata <= rd_next;
            end
            if (low_rd) begin
                shadow_q <= count[CW-1:DW];
            end
        end
    end
endmodule

// File: rtl/ctr_nib_regif.sv
// Module: ctr_nib_regif
// Top of the nibble-wide counter register interface: configuration
// registers, counter core and read port with shadow.
// Assumes: single processor master, strobes synchronous to clk.
module ctr_nib_regif
    import ctr_nib_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    logic [CW-1:0]    init_q;
    logic             en_q;
    cnt_dir_e         dir_q;
    logic             load_q;
    logic [CW-1:0]    count_q;
    logic [CW-DW-1:0] shadow_q;

    ctr_nib_cfg #(.CW(CW), .DW(DW), .AW(AW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (wr_en),
        .addr   (addr),
        .wdata  (wdata),
        .init_q (init_q),
        .en_q   (en_q),
        .dir_q  (dir_q),
        .load_q (load_q)
    );

    ctr_nib_core #(.CW(CW)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (load_q),
        .init    (init_q),
        .en      (en_q),
        .dir     (dir_q),
        .count_q (count_q)
    );

    ctr_nib_rdport #(.CW(CW), .DW(DW), .AW(AW)) u_rd (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_en    (rd_en),
        .addr     (addr),
        .count    (count_q),
        .init     (init_q),
        .en       (en_q),
        .dir      (dir_q),
        .shadow_q (shadow_q),
        .rdata    (rdata)
    );
endmodule

// File: rtl/ctr_nib_chk.sv
// Module: ctr_nib_chk
// Assertion checker bound to ctr_nib_regif. It watches the count, the
// shadow and the read data over time.
// Assumes: same parameters as the bound instance.
module ctr_nib_chk
    import ctr_nib_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rd_en,
    input logic [AW-1:0]    addr,
    input logic [DW-1:0]    rdata,
    input logic [CW-1:0]    count_q,
    input logic [CW-DW-1:0] shadow_q,
    input logic             load_q,
    input logic             en_q,
    input logic             dir_q,
    input logic [CW-1:0]    init_q
);
    localparam int NPIECE = (CW + DW - 1) / DW;
    localparam int A_CNT0 = NPIECE + 1;

    // R3 / R9: a load pulse puts the start value into the count
    p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
        load_q |=> count_q == $past(init_q));

    // R4: enabled up step
    p_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_q && en_q && !dir_q) |=> count_q == CW'($past(count_q) + 1'b1));

    // R4: disabled counter holds
    p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_q && !en_q) |=> $stable(count_q));

    // R5: enabled down step
    p_down_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_q && en_q && dir_q) |=> count_q == CW'($past(count_q) - 1'b1));

    // R6: a low read snapshots the upper count bits and returns the live low bits
    p_snap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(A_CNT0)) |=>
            (shadow_q == $past(count_q[CW-1:DW]) && rdata == $past(count_q[DW-1:0])));

    // R7: a middle read returns the shadow
    p_mid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(A_CNT0 + 1)) |=> rdata == $past(shadow_q[DW-1:0]));

    // R7: a top read returns the top shadow bits, zero-filled
    p_top_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && addr == AW'(A_CNT0 + NPIECE - 1)) |=>
            rdata == DW'($past(shadow_q) >> ((NPIECE - 2) * DW)));

    // R8: the shadow is kept until the next low read
    p_shadow_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && addr == AW'(A_CNT0)) |=> $stable(shadow_q));

    // R10: read data holds without a read strobe
    p_rd_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata));
endmodule

bind ctr_nib_regif ctr_nib_chk #(.CW(CW), .DW(DW), .AW(AW)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .addr     (addr),
    .rdata    (rdata),
    .count_q  (count_q),
    .shadow_q (shadow_q),
    .load_q   (load_q),
    .en_q     (en_q),
    .dir_q    (dir_q),
    .init_q   (init_q)
);

// File: tb/tb_ctr_nib_regif.sv
// Bench for ctr_nib_regif. A behavioural reference model, updated on every
// rising edge, predicts rdata, and the prediction is compared on every
// falling edge. Directed scenarios add explicit checks with hand-worked
// expected values.
module tb_ctr_nib_regif;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] addr = '0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [3:0] wdata = '0;
    logic [3:0] rdata;

    int    n_chk = 0;
    int    n_bad = 0;
    bit    cmp_on = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R1";

    // reference model state
    int m_cnt, m_init, m_en, m_dir, m_load, m_shd, m_rd, m_snap;

    always #10 clk = ~clk;   // 50 MHz

    ctr_nib_regif dut (
        .clk   (clk),
        .rst_n (rst_n),
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .wdata (wdata),
        .rdata (rdata)
    );

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // Reference model: every new value is computed from the values before the edge
    always @(posedge clk) begin
        int nc, rv, w;
        if (!rst_n) begin
            m_cnt = 0; m_init = 0; m_en = 0; m_dir = 0;
            m_load = 0; m_shd = 0; m_rd = 0;
        end else begin
            w = int'(wdata);
            if (m_load != 0)     nc = m_init;
            else if (m_en != 0)  nc = (m_dir != 0) ? (m_cnt + 1023) % 1024 : (m_cnt + 1) % 1024;
            else                 nc = m_cnt;
            rv = m_rd;
            if (rd_en) begin
                case (addr)
                    3'd0: rv = m_init & 15;
                    3'd1: rv = (m_init >> 4) & 15;
                    3'd2: rv = (m_init >> 8) & 3;
                    3'd3: rv = (m_dir << 2) | (m_en << 1);
                    3'd4: begin rv = m_cnt & 15; m_shd = m_cnt >> 4; m_snap = m_cnt; end
                    3'd5: rv = m_shd & 15;
                    3'd6: rv = (m_shd >> 4) & 3;
                    default: rv = 0;
                endcase
            end
            m_load = (wr_en && addr == 3'd3 && w[0]) ? 1 : 0;
            if (wr_en) begin
                case (addr)
                    3'd0: m_init = (m_init & ~15)  | w;
                    3'd1: m_init = (m_init & ~240) | (w << 4);
                    3'd2: m_init = (m_init & ~768) | ((w & 3) << 8);
                    3'd3: begin m_en = (w >> 1) & 1; m_dir = (w >> 2) & 1; end
                    default: ;
                endcase
            end
            m_rd  = rv;
            m_cnt = nc;
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (cmp_on) check({cur_req, " model"}, int'(rdata), m_rd);
    end

    task automatic wr(input int a, input int d);
        @(negedge clk);
        wr_en = 1'b1; addr = 3'(a); wdata = 4'(d);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int a, output int v);
        @(negedge clk);
        rd_en = 1'b1; addr = 3'(a);
        @(negedge clk);
        v = int'(rdata);
        rd_en = 1'b0;
    endtask

    task automatic rd_count(output int v);
        int lo, mi, hi;
        rd(4, lo); rd(5, mi); rd(6, hi);
        v = (hi << 8) | (mi << 4) | lo;
    endtask

    task automatic set_init(input int v);
        wr(0, v & 15); wr(1, (v >> 4) & 15); wr(2, (v >> 8) & 3);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        int v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        cmp_on = 1'b1;

        // R1: everything reads zero after reset
        cur_req = "R1";
        for (int a = 0; a < 8; a++) begin
            rd(a, v);
            check("R1 reset read", v, 0);
        end

        // R2: start-value pieces, zero-filled top piece, unmapped address
        cur_req = "R2";
        wr(0, 5); wr(1, 4'hA); wr(2, 4'hF);
        rd(0, v); check("R2 piece0", v, 5);
        rd(1, v); check("R2 piece1", v, 4'hA);
        rd(2, v); check("R2 piece2", v, 3);
        rd(7, v); check("R2 unmapped", v, 0);

        // R3: load with counter disabled; load bit reads 0
        cur_req = "R3";
        wr(3, 1);
        rd(3, v); check("R3 load bit self-clears", v, 0);
        rd_count(v); check("R3 loaded count", v, 'h3A5);

        // R7: middle and top come from the shadow, top upper bits zero
        cur_req = "R7";
        rd(6, v); check("R7 top piece zero-filled", v, 3);

        // R4: up count wraps 3FE -> 3FF -> 000 in two enabled edges
        cur_req = "R4";
        set_init('h3FE); wr(3, 1);
        wr(3, 2); wr(3, 0);
        rd(3, v); check("R4 ctrl readback", v, 0);
        rd_count(v); check("R4 up wrap", v, 'h000);
        rd_count(v); check("R4 holds when disabled", v, 'h000);

        // R5: down count wraps 000 -> 3FF -> 3FE
        cur_req = "R5";
        wr(3, 6); wr(3, 4);
        rd(3, v); check("R5 ctrl readback", v, 4);
        rd_count(v); check("R5 down wrap", v, 'h3FE);

        // R9: load and enabled step on the same edge -> load wins
        cur_req = "R9";
        set_init('h123);
        @(negedge clk); wr_en = 1'b1; addr = 3'd3; wdata = 4'h3;
        @(negedge clk); wdata = 4'h0;
        @(negedge clk); wr_en = 1'b0;
        rd_count(v); check("R9 load priority", v, 'h123);

        // R8: the shadow is kept across a later load
        cur_req = "R8";
        rd(4, v); check("R6 low nibble", v, 3);
        set_init('h3C0); wr(3, 1);
        rd(5, v); check("R8 middle keeps shadow", v, 2);
        rd(6, v); check("R8 top keeps shadow", v, 1);
        rd_count(v); check("R8 new snapshot", v, 'h3C0);

        // R6: coherent read while the counter runs up, then down
        cur_req = "R6";
        wr(3, 2);
        for (int i = 0; i < 6; i++) begin
            rd_count(v); check("R6 running up coherent", v, m_snap);
        end
        wr(3, 6);
        for (int i = 0; i < 6; i++) begin
            rd_count(v); check("R6 running down coherent", v, m_snap);
        end
        wr(3, 0);

        // R10: read data holds through idle and write cycles
        cur_req = "R10";
        rd(5, v);
        wr(0, 4'h9); wr(3, 2); wr(3, 0);
        repeat (3) @(negedge clk);
        check("R10 rdata held", int'(rdata), v);

        repeat (2) @(negedge clk);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule